// File: doc/BRIEF.md
# Flow-Table Negative-Edge Toggle Cell

This block is a toggle storage element built as an explicit flow-table state machine, not as a behavioural edge-triggered flip-flop. A toggle-enable input and a level input that acts as a local clock are first synchronised to a free-running system clock. The machine then walks through the four rows of a merged flow table on that clock. The stored bit is complemented only when the toggle enable is high and the level input falls. Every other input change leaves the stored bit as it was.

The two state variables are coded so that each allowed row change flips exactly one of them. The output is simply the low state variable, so no output decoder is needed. Alongside the row, the block keeps an index of the current primitive total state for debug. It also raises a one-cycle error flag when both synchronised inputs change in the same sample, which breaks the single-input-change rule. The state is frozen for that sample.

Top module: `ftog_cell`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block enters the state with toggle=0, level=0 and stored bit 0. After that edge, `q_o`=0, `row_o`=2'b10, `prim_o`=4 and `err_o`=0.
- R2: When `tog_i`=1 is held and `trg_i` falls from 1 to 0 as a single input change, `q_o` is complemented.
- R3: A rise of `trg_i`, or any change of `tog_i`, made as a single input change, leaves `q_o` unchanged.
- R4: After each stable sample, `prim_o` encodes the (toggle, level, stored bit) total state as follows:
  - 0: (1,1,0)
  - 1: (1,0,1)
  - 2: (1,1,1)
  - 3: (1,0,0)
  - 4: (0,0,0)
  - 5: (0,1,0)
  - 6: (0,0,1)
  - 7: (0,1,1)
- R5: `row_o` holds the merged row code {Y1,Y2}. The row holding primitive states 0 and 5 is coded 00; the row holding 1, 6 and 7 is coded 01; the row holding 2 and 7 is coded 11; the row holding 3, 4 and 5 is coded 10. No clock edge changes more than one bit of `row_o`.
- R6: `q_o` always equals `row_o[0]` (Y2).
- R7: When both synchronised inputs differ from their previous sampled values in the same cycle, `err_o` is 1 for exactly that one cycle, and `row_o`, `q_o` and `prim_o` keep their values in that cycle.
- R8: With `SYNC_STAGES`=2, a single input change applied before rising edge k shows up on `q_o` after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| tog_i | input | 1 | Toggle enable (asynchronous) |
| trg_i | input | 1 | Level input whose falling edge toggles (asynchronous) |
| q_o | output | 1 | Stored bit, equal to Y2 |
| row_o | output | 2 | Merged flow-table row code {Y1,Y2} |
| prim_o | output | 3 | Primitive total-state index |
| err_o | output | 1 | One-cycle pulse on a double input change |

## Verification
A wrong row code appears within one stable sample. Either `q_o` breaks from a shadow bit that counts falling level edges while toggle is high, or `prim_o` no longer matches the (toggle, level, stored bit) triple presented at the pins. A walk of single input changes visits every primitive state and every row transition. It is checked after each step, and bit flips of `row_o` are counted on every cycle. A deliberate double change confirms that the error pulse comes at the predicted cycle and that the state is frozen only for that cycle.

// File: rtl/ftog_pkg.sv
package ftog_pkg;

   localparam int ROW_W  = 2;
   localparam int PRIM_W = 3;

   typedef logic [ROW_W-1:0]  row_t;
   typedef logic [PRIM_W-1:0] prim_t;

   // merged rows, Gray ordered around the cycle 00 -> 01 -> 11 -> 10 -> 00
   localparam row_t ROW_P0 = 2'b00;   // primitive 0, 5
   localparam row_t ROW_P1 = 2'b01;   // primitive 1, 6, 7
   localparam row_t ROW_P2 = 2'b11;   // primitive 2, 7
   localparam row_t ROW_P3 = 2'b10;   // primitive 3, 4, 5

   localparam prim_t PRIM_RESET = 3'd4;

   // primitive index from stored bit and sampled inputs
   function automatic prim_t prim_of(input logic q, input logic t, input logic c);
      prim_t p;
      unique case ({q, t, c})
         3'b011:  p = 3'd0;
         3'b110:  p = 3'd1;
         3'b111:  p = 3'd2;
         3'b010:  p = 3'd3;
         3'b000:  p = 3'd4;
         3'b001:  p = 3'd5;
         3'b100:  p = 3'd6;
         default: p = 3'd7;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ftog_sync.sv
module ftog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("ftog_sync: STAGES must lie in 2..4");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= 1'b0;
            else     chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/ftog_table.sv
module ftog_table
   import ftog_pkg::*;
(
   input  row_t row_i,
   input  logic t_i,
   input  logic c_i,
   input  logic hold_i,
   output row_t row_o
);

   row_t step;

   always_comb begin
      step = row_i;
      unique case (row_i)
         ROW_P0: begin
            if (t_i && !c_i)       step = ROW_P1;   // level falls, toggle high
            else if (!t_i && !c_i) step = ROW_P3;   // level falls, toggle low
         end
         ROW_P1: begin
            if (t_i && c_i)        step = ROW_P2;
         end
         ROW_P2: begin
            if (t_i && !c_i)       step = ROW_P3;   // level falls, toggle high
            else if (!t_i && !c_i) step = ROW_P1;
         end
         default: begin
            if (t_i && c_i)        step = ROW_P0;
         end
      endcase
   end

   assign row_o = hold_i ? row_i : step;

endmodule

// File: rtl/ftog_prim.sv
module ftog_prim
   import ftog_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  hold_i,
   input  logic  q_next_i,
   input  logic  t_i,
   input  logic  c_i,
   output prim_t prim_o
);

   prim_t prim_q;

   always_ff @(posedge clk) begin
      if (rst)          prim_q <= PRIM_RESET;
      else if (!hold_i) prim_q <= prim_of(q_next_i, t_i, c_i);
   end

   assign prim_o = prim_q;

endmodule

// File: rtl/ftog_cell.sv
module ftog_cell
   import ftog_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tog_i,
   input  logic              trg_i,
   output logic              q_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [PRIM_W-1:0] prim_o,
   output logic              err_o
);

   logic t_s, c_s;
   logic t_p, c_p;
   logic dbl;
   row_t row_q, row_d;
   logic err_q;

   ftog_sync #(.STAGES(SYNC_STAGES)) u_sync_t (
      .clk(clk), .rst(rst), .d_i(tog_i), .q_o(t_s)
   );

   ftog_sync #(.STAGES(SYNC_STAGES)) u_sync_c (
      .clk(clk), .rst(rst), .d_i(trg_i), .q_o(c_s)
   );

   assign dbl = (t_s ^ t_p) & (c_s ^ c_p);

   ftog_table u_table (
      .row_i(row_q), .t_i(t_s), .c_i(c_s), .hold_i(dbl), .row_o(row_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= ROW_P3;
         t_p   <= 1'b0;
         c_p   <= 1'b0;
         err_q <= 1'b0;
      end else begin
         row_q <= row_d;
         t_p   <= t_s;
         c_p   <= c_s;
         err_q <= dbl;
      end
   end

   ftog_prim u_prim (
      .clk(clk), .rst(rst), .hold_i(dbl), .q_next_i(row_d[0]),
      .t_i(t_s), .c_i(c_s), .prim_o(prim_o)
   );

   assign row_o = row_q;
   assign q_o   = row_q[0];
   assign err_o = err_q;

endmodule

// File: rtl/ftog_cell_chk.sv
module ftog_cell_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] row,
   input logic       q,
   input logic [2:0] prim,
   input logic       err,
   input logic       t_s,
   input logic       c_s
);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (row == 2'b10 && prim == 3'd4 && !err));

   assert_toggle_cause_R2: assert property (@(posedge clk) disable iff (rst)
      (q != $past(q)) |-> ($past(t_s) && !$past(c_s)));

   assert_prim_matches_q_R4: assert property (@(posedge clk) disable iff (rst)
      q == (prim == 3'd1 || prim == 3'd2 || prim == 3'd6 || prim == 3'd7));

   assert_one_var_R5: assert property (@(posedge clk) disable iff (rst)
      $countones(row ^ $past(row)) <= 1);

   assert_err_freeze_R7: assert property (@(posedge clk) disable iff (rst)
      err |-> ($stable(row) && $stable(prim)));

endmodule

bind ftog_cell ftog_cell_chk u_chk (
   .clk(clk), .rst(rst), .row(row_o), .q(q_o), .prim(prim_o),
   .err(err_o), .t_s(t_s), .c_s(c_s)
);

// File: tb/ftog_cell_bench.sv
module ftog_cell_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tog = 1'b0;
   logic       trg = 1'b0;
   logic       q;
   logic [1:0] row;
   logic [2:0] prim;
   logic       err;

   int n_cmp = 0;
   int n_bad = 0;
   int adj_bad = 0;
   bit done = 0;
   logic shadow = 1'b0;
   logic t_cur = 1'b0;
   logic c_cur = 1'b0;
   logic [1:0] row_prev = 2'b10;

   always #4 clk = ~clk;

   ftog_cell u_ftog_cell (
      .clk(clk), .rst(rst), .tog_i(tog), .trg_i(trg),
      .q_o(q), .row_o(row), .prim_o(prim), .err_o(err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // index of (toggle, level, stored bit), per R4
   function automatic int exp_prim(input logic t, input logic c, input logic s);
      case ({t, c, s})
         3'b110: return 0;
         3'b101: return 1;
         3'b111: return 2;
         3'b100: return 3;
         3'b000: return 4;
         3'b010: return 5;
         3'b001: return 6;
         default: return 7;
      endcase
   endfunction

   always @(negedge clk) begin
      if (!rst) begin
         if (((row ^ row_prev) == 2'b11)) adj_bad++;
      end
      row_prev = row;
   end

   task automatic apply(input logic nt, input logic nc);
      logic flip;
      flip = (t_cur && nt && c_cur && !nc);
      tog = nt;
      trg = nc;
      repeat (5) @(negedge clk);
      if (flip) shadow = ~shadow;
      t_cur = nt;
      c_cur = nc;
      if (flip) check("R2 toggle on falling level", int'(q), int'(shadow));
      else      check("R3 hold on other change", int'(q), int'(shadow));
      check("R4 primitive index", int'(prim), exp_prim(t_cur, c_cur, shadow));
      check("R6 q equals Y2", int'(q), int'(row[0]));
      check("R7 no error on single change", int'(err), 0);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      logic [1:0] held;
      repeat (3) @(negedge clk);
      check("R1 reset q", int'(q), 0);
      check("R1 reset row", int'(row), 2);
      check("R1 reset prim", int'(prim), 4);
      check("R1 reset err", int'(err), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      apply(1'b1, 1'b0);
      apply(1'b1, 1'b1);
      // latency of a falling level edge with toggle high (R8)
      trg = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 unchanged after two edges", int'(q), 0);
      @(negedge clk);
      check("R8 toggled after three edges", int'(q), 1);
      shadow = 1'b1;
      c_cur = 1'b0;
      repeat (2) @(negedge clk);

      // walk of single input changes
      lf = 8'hA5;
      for (int i = 0; i < 160; i++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         if (lf[0]) apply(~t_cur, c_cur);
         else       apply(t_cur, ~c_cur);
      end

      // double change from (0,0) to (1,1)
      apply(1'b0, c_cur);
      apply(1'b0, 1'b0);
      held = row;
      tog = 1'b1;
      trg = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 no error before the sample", int'(err), 0);
      @(negedge clk);
      check("R7 error pulse", int'(err), 1);
      check("R7 row frozen", int'(row), int'(held));
      check("R7 q frozen", int'(q), int'(shadow));
      @(negedge clk);
      check("R7 error lasts one cycle", int'(err), 0);
      t_cur = 1'b1;
      c_cur = 1'b1;
      repeat (2) @(negedge clk);
      check("R4 primitive after double change", int'(prim), exp_prim(1'b1, 1'b1, shadow));
      check("R3 q kept after double change", int'(q), int'(shadow));

      check("R5 two-bit row flips", adj_bad, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule